// File: doc/BRIEF.md
# Tiled Surface Address Walker

This block turns a rectangle of element coordinates on a 2-D surface into a stream of byte addresses. The surface can be stored plain (row after row) or in one of four 4 KB tile layouts. In a tiled layout, neighbouring pixels in both directions stay close in memory. A client sets up the surface description and pulses a start command carrying the rectangle origin, width and height. The surface description is the base address, the row pitch, the element size, the layout code and a swizzle enable. The block then visits every element of the rectangle, one address per accepted handshake, and marks the end with a single-cycle done pulse.

Inside a tile, each layout builds the 12-bit offset by placing bits of the byte column and of the row into a fixed bit order of its own. Whole tiles are placed in row-major order. One tile row spans the pitch times the tile's physical row count. Each tile column adds 4096 bytes. The stencil layout stores each pair of logical rows in one physical row, so it expects a doubled pitch. The two oldest tiled layouts can fold higher address bits into bit 6.

The controller has three states. IDLE waits for a command. RUN presents addresses. FIN raises done for one cycle. Transitions:
- IDLE→RUN: start with a non-empty rectangle.
- IDLE→FIN: start with zero width or zero height.
- RUN→RUN: until the last element is accepted.
- RUN→FIN: on acceptance of the last element.
- FIN→IDLE: always.

Top module: `tiled_addr_gen`

## Requirements
- R1: After reset, out_valid, done and busy are all low, and out_valid stays low whenever busy is low.
- R2: For a rectangle of W×H elements at origin (X0,Y0), exactly W×H addresses are produced, column index fastest and then row, covering x = X0..X0+W-1 and y = Y0..Y0+H-1.
- R3: While out_valid is high and out_ready is low, out_valid stays high and out_addr does not change on the next cycle.
- R4: done is high for exactly one cycle, in the cycle after the last address is accepted, with out_valid low; busy is low from the following cycle.
- R5: Mode code 0 (plain; codes 5 to 7 behave the same) gives base + y×pitch + b, where b is the byte column. No tile split is applied.
- R6: Mode code 1 uses tiles 512 B × 8 rows. The tile column is b/512 and the tile row is y/8. The offset is tile_row×pitch×8 + tile_col×4096 + (y mod 8)×512 + (b mod 512).
- R7: Mode code 2 uses tiles 128 B × 32 rows. With u = b mod 128 and v = y mod 32, the in-tile offset is (u/16)×512 + v×16 + (u mod 16). The tile row spans pitch×32.
- R8: Mode code 3 (stencil) uses logical tiles of 64 bytes × 64 rows, with tile column b/64, tile row y/64 and row span pitch×32. Let u = b mod 64 and v = y mod 64. The in-tile offset is then built from LSB to MSB as u0, v0, u1, v1, u2, v2, v3, v4, v5, u3, u4, u5.
- R9: Mode code 4 uses the same tile split as code 2. From LSB upward, the in-tile offset is u0..u3, v0, v1, u4, u5, v2, u6, v3, v4.
- R10: The byte column is b = x × 2^S, where S is the 3-bit element-size code (0 to 4 for 1 to 16 bytes), so the low S offset bits are always zero.
- R11: With the swizzle enable set, mode 1 outputs bit6 XOR bit9 XOR bit10 in bit 6, and mode 2 outputs bit6 XOR bit9 in bit 6. Modes 0, 3 and 4 never alter bit 6.
- R12: A start pulse while busy has no effect on the running stream. Surface and rectangle inputs are captured when the command is accepted, and later changes to them are ignored.
- R13: A start with zero width or zero height yields no address and a single done pulse one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | ADDR_W | Surface base address, 4 KB aligned |
| cfg_pitch | input | PITCH_W | Row pitch in bytes |
| cfg_size_log2 | input | 3 | Element size as log2 of bytes |
| cfg_mode | input | 3 | Layout code 0..4 |
| cfg_swz_en | input | 1 | Bit-6 fold enable |
| start | input | 1 | Command strobe |
| org_x | input | COORD_W | Rectangle origin column (elements) |
| org_y | input | COORD_W | Rectangle origin row |
| rect_w | input | COORD_W | Rectangle width in elements |
| rect_h | input | COORD_W | Rectangle height in rows |
| out_valid | output | 1 | Address valid |
| out_ready | input | 1 | Consumer accepts address |
| out_addr | output | ADDR_W | Byte address of current element |
| done | output | 1 | One-cycle end-of-rectangle pulse |
| busy | output | 1 | Command in progress |

## Verification
Each layout code is run with rectangles whose origin sits just before a tile edge, so that the stream crosses both tile-column and tile-row boundaries. A wrong tile width, tile height or row span therefore shows up as a jump to the wrong tile. Element sizes of 1, 4 and 16 bytes separate the byte scaling from the bit placement. The swizzle enable is toggled on modes 1 and 2, and set on modes 0, 3 and 4, where it must not change anything. The pitch is chosen so that bits 9 and 10 vary. Randomised back-pressure exercises the hold rule. A restart pulse mid-run and changed inputs during a run show that commands are captured only on acceptance. An empty rectangle checks the direct path from IDLE to FIN.

// File: rtl/tag_pkg.sv
package tag_pkg;
    typedef enum logic [2:0] {
        MODE_LINEAR = 3'd0,
        MODE_XT     = 3'd1,
        MODE_YT     = 3'd2,
        MODE_WT     = 3'd3,
        MODE_T4     = 3'd4
    } tile_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } walk_state_e;

    localparam int TILE_LOG2 = 12;
endpackage

// File: rtl/tag_walker.sv
module tag_walker
    import tag_pkg::*;
#(
    parameter int COORD_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [COORD_W-1:0] rect_w,
    input  logic [COORD_W-1:0] rect_h,
    input  logic               out_ready,
    output logic               out_valid,
    output logic               done,
    output logic               busy,
    output logic               launch,
    output logic [COORD_W-1:0] col,
    output logic [COORD_W-1:0] row
);
    walk_state_e        state_q, state_d;
    logic [COORD_W-1:0] w_q, h_q;
    logic               empty_rect, fire, last_col, last_row;

    assign empty_rect = (rect_w == '0) || (rect_h == '0);
    assign launch     = start && (state_q == ST_IDLE);
    assign fire       = out_valid && out_ready;
    assign last_col   = (col == w_q - COORD_W'(1));
    assign last_row   = (row == h_q - COORD_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = empty_rect ? ST_FIN : ST_RUN;
            ST_RUN:  if (fire && last_col && last_row) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        done      = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_IDLE: busy      = 1'b0;
            ST_RUN:  out_valid = 1'b1;
            ST_FIN:  done      = 1'b1;
            default: busy      = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
            h_q <= '0;
            col <= '0;
            row <= '0;
        end else if (launch) begin
            w_q <= rect_w;
            h_q <= rect_h;
            col <= '0;
            row <= '0;
        end else if (fire) begin
            if (last_col) begin
                col <= '0;
                row <= row + COORD_W'(1);
            end else begin
                col <= col + COORD_W'(1);
            end
        end
    end
endmodule

// File: rtl/tag_tile_map.sv
module tag_tile_map
    import tag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 18,
    parameter int COORD_W = 14,
    parameter int BX_W    = COORD_W + 4
) (
    input  tile_mode_e         mode,
    input  logic [ADDR_W-1:0]  base,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [BX_W-1:0]    bx,
    input  logic [COORD_W-1:0] y,
    output logic [ADDR_W-1:0]  addr
);
    localparam int OFS_W = TILE_LOG2;

    logic [ADDR_W-1:0] pitch_a, bx_a, y_a, tcol, trow, span;
    logic [OFS_W-1:0]  intile;
    logic              tiled;

    assign pitch_a = ADDR_W'(pitch);
    assign bx_a    = ADDR_W'(bx);
    assign y_a     = ADDR_W'(y);

    always_comb begin
        tiled  = 1'b1;
        intile = '0;
        tcol   = '0;
        trow   = '0;
        span   = '0;
        unique case (mode)
            MODE_XT: begin
                intile = {y[2:0], bx[8:0]};
                tcol   = bx_a >> 9;
                trow   = y_a >> 3;
                span   = pitch_a << 3;
            end
            MODE_YT: begin
                intile = {bx[6:4], y[4:0], bx[3:0]};
                tcol   = bx_a >> 7;
                trow   = y_a >> 5;
                span   = pitch_a << 5;
            end
            MODE_WT: begin
                intile = {bx[5:3], y[5:2], bx[2], y[1], bx[1], y[0], bx[0]};
                tcol   = bx_a >> 6;
                trow   = y_a >> 6;
                span   = pitch_a << 5;
            end
            MODE_T4: begin
                intile = {y[4:3], bx[6], y[2], bx[5:4], y[1:0], bx[3:0]};
                tcol   = bx_a >> 7;
                trow   = y_a >> 5;
                span   = pitch_a << 5;
            end
            default: tiled = 1'b0;
        endcase
    end

    always_comb begin
        if (tiled)
            addr = base + trow * span + (tcol << TILE_LOG2) + ADDR_W'(intile);
        else
            addr = base + y_a * pitch_a + bx_a;
    end
endmodule

// File: rtl/tag_swizzle.sv
module tag_swizzle
    import tag_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  tile_mode_e        mode,
    input  logic              enable,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    logic fold;

    always_comb begin
        fold = 1'b0;
        if (enable) begin
            unique case (mode)
                MODE_XT: fold = addr_in[9] ^ addr_in[10];
                MODE_YT: fold = addr_in[9];
                default: fold = 1'b0;
            endcase
        end
        addr_out    = addr_in;
        addr_out[6] = addr_in[6] ^ fold;
    end
endmodule

// File: rtl/tiled_addr_gen.sv
module tiled_addr_gen
    import tag_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 18,
    parameter int COORD_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cfg_base,
    input  logic [PITCH_W-1:0] cfg_pitch,
    input  logic [2:0]         cfg_size_log2,
    input  logic [2:0]         cfg_mode,
    input  logic               cfg_swz_en,
    input  logic               start,
    input  logic [COORD_W-1:0] org_x,
    input  logic [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0] rect_w,
    input  logic [COORD_W-1:0] rect_h,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               done,
    output logic               busy
);
    localparam int BX_W = COORD_W + 4;

    logic               launch;
    logic [COORD_W-1:0] col, row;
    logic [ADDR_W-1:0]  base_q;
    logic [PITCH_W-1:0] pitch_q;
    logic [2:0]         size_q;
    tile_mode_e         mode_q;
    logic               swz_q;
    logic [COORD_W-1:0] ox_q, oy_q;
    logic [COORD_W-1:0] x_abs, y_abs;
    logic [BX_W-1:0]    bx;
    logic [ADDR_W-1:0]  raw_addr;

    tag_walker #(.COORD_W(COORD_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rect_w(rect_w), .rect_h(rect_h), .out_ready(out_ready),
        .out_valid(out_valid), .done(done), .busy(busy),
        .launch(launch), .col(col), .row(row)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            pitch_q <= '0;
            size_q  <= '0;
            mode_q  <= MODE_LINEAR;
            swz_q   <= 1'b0;
            ox_q    <= '0;
            oy_q    <= '0;
        end else if (launch) begin
            base_q  <= cfg_base;
            pitch_q <= cfg_pitch;
            size_q  <= (cfg_size_log2 > 3'd4) ? 3'd4 : cfg_size_log2;
            mode_q  <= tile_mode_e'(cfg_mode);
            swz_q   <= cfg_swz_en;
            ox_q    <= org_x;
            oy_q    <= org_y;
        end
    end

    assign x_abs = ox_q + col;
    assign y_abs = oy_q + row;
    assign bx    = BX_W'(x_abs) << size_q;

    tag_tile_map #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .COORD_W(COORD_W), .BX_W(BX_W)
    ) u_map (
        .mode(mode_q), .base(base_q), .pitch(pitch_q),
        .bx(bx), .y(y_abs), .addr(raw_addr)
    );

    tag_swizzle #(.ADDR_W(ADDR_W)) u_swz (
        .mode(mode_q), .enable(swz_q), .addr_in(raw_addr), .addr_out(out_addr)
    );
endmodule

module tag_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              done
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !done));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    p_launch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));
endmodule

bind tiled_addr_gen tag_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .done(done)
);

// File: tb/tiled_addr_gen_tb.sv
module tiled_addr_gen_tb_top;
    localparam int ADDR_W = 32, PITCH_W = 18, COORD_W = 14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ADDR_W-1:0]  cfg_base = '0;
    logic [PITCH_W-1:0] cfg_pitch = '0;
    logic [2:0]         cfg_size_log2 = '0, cfg_mode = '0;
    logic               cfg_swz_en = 1'b0, start = 1'b0, out_ready = 1'b0;
    logic [COORD_W-1:0] org_x = '0, org_y = '0, rect_w = '0, rect_h = '0;
    logic               out_valid, done, busy;
    logic [ADDR_W-1:0]  out_addr;

    always #2.5 clk = ~clk;

    tiled_addr_gen #(.ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .COORD_W(COORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_pitch(cfg_pitch),
        .cfg_size_log2(cfg_size_log2), .cfg_mode(cfg_mode), .cfg_swz_en(cfg_swz_en),
        .start(start), .org_x(org_x), .org_y(org_y), .rect_w(rect_w), .rect_h(rect_h),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .done(done), .busy(busy)
    );

    int total = 0, bad = 0, done_seen = 0;
    bit finished = 0, hold_pend = 0, prev_done = 0;
    int ready_mode = 0;
    logic [ADDR_W-1:0] hold_addr;
    longint unsigned exp_q[$];
    string cur_tag = "R1";

    task automatic check(input bit ok, input string req, input longint unsigned act,
                         input longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic longint unsigned ref_addr(input int mode, input longint unsigned base,
            input longint unsigned pitch, input int sl2, input bit swz, input int x, input int y);
        longint unsigned b, u, v, off, a;
        b = longint'(x) << sl2;
        case (mode)
            1: begin
                u = b % 512; v = y % 8;
                off = (y / 8) * pitch * 8 + (b / 512) * 4096 + v * 512 + u;
            end
            2: begin
                u = b % 128; v = y % 32;
                off = (y / 32) * pitch * 32 + (b / 128) * 4096
                      + (u / 16) * 512 + v * 16 + (u % 16);
            end
            3: begin
                u = b % 64; v = y % 64;
                off = (y / 64) * pitch * 32 + (b / 64) * 4096
                      + (u & 1) + (v & 1) * 2 + ((u >> 1) & 1) * 4 + ((v >> 1) & 1) * 8
                      + ((u >> 2) & 1) * 16 + ((v >> 2) & 15) * 32 + ((u >> 3) & 7) * 512;
            end
            4: begin
                u = b % 128; v = y % 32;
                off = (y / 32) * pitch * 32 + (b / 128) * 4096
                      + (u & 15) + (v & 3) * 16 + ((u >> 4) & 3) * 64 + ((v >> 2) & 1) * 256
                      + ((u >> 6) & 1) * 512 + ((v >> 3) & 3) * 1024;
            end
            default: off = longint'(y) * pitch + b;
        endcase
        a = (base + off) & 64'hFFFF_FFFF;
        if (swz && mode == 1) a = a ^ ((((a >> 9) ^ (a >> 10)) & 1) << 6);
        if (swz && mode == 2) a = a ^ (((a >> 9) & 1) << 6);
        return a;
    endfunction

    // back-pressure generator
    always @(posedge clk) begin
        #1;
        out_ready = (ready_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
    end

    // monitor: compares against the reference queue every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (out_valid) begin
                if (hold_pend)
                    check(out_addr == hold_addr, "R3 hold", out_addr, hold_addr);
                if (out_ready) begin
                    hold_pend = 0;
                    if (exp_q.size() == 0) check(0, {cur_tag, " R2 extra address"}, out_addr, 0);
                    else begin
                        longint unsigned e;
                        e = exp_q.pop_front();
                        check(out_addr == e[ADDR_W-1:0], cur_tag, out_addr, e);
                    end
                end else begin
                    hold_pend = 1;
                    hold_addr = out_addr;
                end
            end else begin
                if (hold_pend) check(0, "R3 valid dropped", 0, 1);
                hold_pend = 0;
            end
            if (done) begin
                done_seen++;
                check(exp_q.size() == 0, "R4 done before last", exp_q.size(), 0);
                check(!out_valid, "R4 valid with done", out_valid, 0);
                check(!prev_done, "R4 done width", 1, 0);
            end
            prev_done = done;
        end
    end

    task automatic run(input int mode, input int sl2, input bit swz, input int pitch,
                       input longint unsigned base, input int ox, input int oy,
                       input int w, input int h, input string tag, input bit poke);
        int d0;
        @(posedge clk); #1;
        cur_tag = tag;
        for (int j = 0; j < h; j++)
            for (int i = 0; i < w; i++)
                exp_q.push_back(ref_addr(mode, base, pitch, sl2, swz, ox + i, oy + j));
        cfg_mode = 3'(mode); cfg_size_log2 = 3'(sl2); cfg_swz_en = swz;
        cfg_pitch = PITCH_W'(pitch); cfg_base = ADDR_W'(base);
        org_x = COORD_W'(ox); org_y = COORD_W'(oy);
        rect_w = COORD_W'(w); rect_h = COORD_W'(h);
        d0 = done_seen;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R12: altered inputs and a second start while busy
            cfg_mode = 3'd0; cfg_base = 32'h0000_9000; org_x = 1; rect_w = 2; rect_h = 1;
            repeat (3) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        while (done_seen == d0) @(posedge clk);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(!busy && !out_valid, {tag, " R4 idle after done"}, busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !done && !busy, "R1 reset state", {out_valid, done, busy}, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        run(0, 2, 1'b1, 3000, 64'h0010_0000, 5, 3, 7, 4, "R5 R2 R11 linear", 0);
        run(1, 2, 1'b0, 2048, 64'h0020_0000, 124, 6, 8, 4, "R6 X", 0);
        ready_mode = 1;
        run(1, 2, 1'b1, 2560, 64'h0020_0000, 124, 6, 8, 4, "R6 R11 X swz R3", 0);
        run(2, 0, 1'b1, 1024, 64'h0030_0000, 120, 30, 12, 4, "R7 R11 Y swz", 0);
        run(2, 4, 1'b0, 1024, 64'h0030_0000, 6, 30, 4, 4, "R7 R10 Y 16B", 0);
        run(3, 0, 1'b1, 512, 64'h0040_0000, 60, 62, 8, 4, "R8 R11 W", 0);
        run(4, 1, 1'b1, 1024, 64'h0050_0000, 60, 29, 8, 6, "R9 R10 R11 T4", 0);
        ready_mode = 0;
        run(2, 2, 1'b0, 1024, 64'h0060_0000, 30, 0, 6, 3, "R12 restart ignored", 1);
        run(1, 0, 1'b0, 2048, 64'h0070_0000, 0, 0, 0, 5, "R13 empty", 0);
        run(4, 0, 1'b0, 1024, 64'h0070_0000, 0, 0, 5, 0, "R13 empty rows", 0);

        repeat (4) @(posedge clk);
        finished = 1;
        check(exp_q.size() == 0, "R2 count", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule